// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Integer Core

This block runs a small integer instruction subset (add, sub, ori, lw, sw, beq) through five stages: fetch, decode with register read, execute, memory access and write-back. Registers between the stages carry the operands, the immediate, the incremented PC and the control fields forward, so one instruction can enter and one can leave every cycle.

The core talks to two ideal memories. The instruction port and the data port are both read combinationally in the same cycle. A data write takes effect on the clock edge. The core has no forwarding and no interlock, so software must place enough nops between a producer and its consumer.

Every instruction that writes a register does so in stage 5. An R-type instruction passes through the memory stage without doing anything there, which keeps a single write port on the register file. A taken branch takes effect in the memory stage and cancels the three younger instructions behind it.

Top module: `core_pipe5`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the fetch address is 0 and no data write is issued. Every pipeline register resets to a nop.
- R2: When no branch is taken, the fetch address rises by 4 every cycle, starting at 0 after reset.
- R3: An R-type word (bits 31:26 = 0, bits 10:6 = 0) with bits 5:0 = 0x20 writes rs+rt into rd, and with bits 5:0 = 0x22 writes rs-rt into rd. Source fields are at bits 25:21 and 20:16, and the destination is at bits 15:11.
- R4: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits 15:0) into rt.
- R5: Opcode 0x23 loads the data word at rs plus the sign-extended immediate into rt. The data is available to an instruction fetched three slots later.
- R6: Opcode 0x2B writes rt to the data address rs plus the sign-extended immediate. The write is issued in the fourth cycle after the store is fetched, and the store writes no register.
- R7: Opcode 0x04 compares rs and rt. If they are equal, the fetch address in the cycle after the branch's memory stage is the branch's PC+4 plus the sign-extended immediate times 4. The three younger instructions are then cancelled, and none of them writes memory or a register.
- R8: Register 0 always reads as zero, and writes to it are ignored.
- R9: A register written in stage 5 is seen by a read in stage 2 in the same cycle, so two nops are enough between a producer and its consumer.
- R10: Independent instructions complete one per cycle, so back-to-back stores write in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction fetch byte address (the PC) |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o, valid in the same cycle |
| dmem_addr_o | output | 32 | Data byte address from the memory stage |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Data write enable |
| dmem_rdata_i | input | 32 | Data word at dmem_addr_o, valid in the same cycle |

## Verification
Three programs are used, and each is observed only through the stores it makes, which are compared for address, data and the exact cycle. The first is a dense arithmetic program. Its operand values separate add from sub and zero-extension from sign-extension, it tries a write to register 0, and it separates a producer from its consumer by exactly two nops, which catches a missing same-cycle write-through. The second program loads through a negative displacement and reuses the loaded value, which tells a correct load path apart from an ALU-result path. The third program has an untaken branch followed by a taken one whose shadow holds stores and a register write. It shows whether the flush covers exactly three slots and whether the redirect lands in the right cycle.

// File: rtl/core_pkg.sv
`timescale 1ns/1ps
package core_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    mem_rd;
    logic    branch;
    logic    use_imm;
    logic    zero_ext;
    logic    dst_rd;
    alu_op_e alu_op;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [31:0]     instr;
  } if_id_t;

  typedef struct packed {
    ctrl_t           ctrl;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [15:0]     imm;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  rd;
  } id_ex_t;

  typedef struct packed {
    logic            reg_we;
    logic            mem_we;
    logic            mem_rd;
    logic            branch;
    logic            zero;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] store_d;
    logic [RAW-1:0]  wreg;
  } ex_mem_t;

  typedef struct packed {
    logic            reg_we;
    logic            mem_rd;
    logic [RAW-1:0]  wreg;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] load_d;
  } mem_wb_t;
endpackage

// File: rtl/core_decode.sv
`timescale 1ns/1ps
module core_decode
  import core_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);
  logic [5:0] op, fn;
  logic       shamt_zero;

  assign op         = instr_i[31:26];
  assign fn         = instr_i[5:0];
  assign shamt_zero = (instr_i[10:6] == 5'd0);

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_RTYPE: begin
        if (shamt_zero && fn == FN_ADD) begin
          ctrl_o.reg_we = 1'b1; ctrl_o.dst_rd = 1'b1; ctrl_o.alu_op = ALU_ADD;
        end else if (shamt_zero && fn == FN_SUB) begin
          ctrl_o.reg_we = 1'b1; ctrl_o.dst_rd = 1'b1; ctrl_o.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.zero_ext = 1'b1; ctrl_o.alu_op = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.mem_rd = 1'b1;
        ctrl_o.use_imm = 1'b1; ctrl_o.alu_op = ALU_ADD;
      end
      OP_SW: begin
        ctrl_o.mem_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.alu_op = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1; ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
`timescale 1ns/1ps
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs [NREG];
  logic         wr_ok;

  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  // write-before-read: same-cycle write-back is visible to decode
  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
    if (a == '0)                 return '0;
    else if (wr_ok && a == waddr_i) return wdata_i;
    else                         return regs[a];
  endfunction

  assign rdata_a_o = rd_port(raddr_a_i);
  assign rdata_b_o = rd_port(raddr_b_i);
endmodule

// File: rtl/core_alu.sv
`timescale 1ns/1ps
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/core_pipe5.sv
`timescale 1ns/1ps
module core_pipe5
  import core_pkg::*;
#(
  parameter logic [XLEN-1:0] PC_RESET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int NREG = 1 << RAW;

  logic [XLEN-1:0] pc_q, pc4_f;
  if_id_t          if_id_q, if_id_d;
  id_ex_t          id_ex_q, id_ex_d;
  ex_mem_t         ex_mem_q, ex_mem_d;
  mem_wb_t         mem_wb_q, mem_wb_d;
  logic            br_taken;

  // IF
  assign pc4_f       = pc_q + XLEN'(4);
  assign imem_addr_o = pc_q;
  assign if_id_d     = '{pc4: pc4_f, instr: imem_rdata_i};

  // ID
  ctrl_t           dec_ctrl;
  logic [RAW-1:0]  rs_addr, rt_addr;
  logic [XLEN-1:0] rs_data, rt_data, wb_data;

  assign rs_addr = if_id_q.instr[25:21];
  assign rt_addr = if_id_q.instr[20:16];
  assign wb_data = mem_wb_q.mem_rd ? mem_wb_q.load_d : mem_wb_q.alu_y;

  core_decode u_dec (.instr_i(if_id_q.instr), .ctrl_o(dec_ctrl));

  core_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mem_wb_q.reg_we),
    .waddr_i   (mem_wb_q.wreg),
    .wdata_i   (wb_data),
    .raddr_a_i (rs_addr),
    .raddr_b_i (rt_addr),
    .rdata_a_o (rs_data),
    .rdata_b_o (rt_data)
  );

  assign id_ex_d = '{ctrl: dec_ctrl, pc4: if_id_q.pc4, opa: rs_data, opb: rt_data,
                     imm: if_id_q.instr[15:0], rt: rt_addr, rd: if_id_q.instr[15:11]};

  // EX
  logic [XLEN-1:0] imm_ext, alu_b, alu_y;
  logic            alu_zero;

  assign imm_ext = id_ex_q.ctrl.zero_ext ? {{(XLEN-16){1'b0}}, id_ex_q.imm}
                                         : {{(XLEN-16){id_ex_q.imm[15]}}, id_ex_q.imm};
  assign alu_b   = id_ex_q.ctrl.use_imm ? imm_ext : id_ex_q.opb;

  core_alu #(.W(XLEN)) u_alu (
    .a_i(id_ex_q.opa), .b_i(alu_b), .op_i(id_ex_q.ctrl.alu_op),
    .y_o(alu_y), .zero_o(alu_zero)
  );

  always_comb begin
    ex_mem_d         = '0;
    ex_mem_d.reg_we  = id_ex_q.ctrl.reg_we;
    ex_mem_d.mem_we  = id_ex_q.ctrl.mem_we;
    ex_mem_d.mem_rd  = id_ex_q.ctrl.mem_rd;
    ex_mem_d.branch  = id_ex_q.ctrl.branch;
    ex_mem_d.zero    = alu_zero;
    ex_mem_d.target  = id_ex_q.pc4 + {imm_ext[XLEN-3:0], 2'b00};
    ex_mem_d.alu_y   = alu_y;
    ex_mem_d.store_d = id_ex_q.opb;
    ex_mem_d.wreg    = id_ex_q.ctrl.dst_rd ? id_ex_q.rd : id_ex_q.rt;
  end

  // MEM
  assign br_taken     = ex_mem_q.branch & ex_mem_q.zero;
  assign dmem_addr_o  = ex_mem_q.alu_y;
  assign dmem_wdata_o = ex_mem_q.store_d;
  assign dmem_we_o    = ex_mem_q.mem_we;
  assign mem_wb_d     = '{reg_we: ex_mem_q.reg_we, mem_rd: ex_mem_q.mem_rd,
                          wreg: ex_mem_q.wreg, alu_y: ex_mem_q.alu_y, load_d: dmem_rdata_i};

  // stage registers; a taken branch squashes IF, ID and EX
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= PC_RESET;
      if_id_q  <= '0;
      id_ex_q  <= '0;
      ex_mem_q <= '0;
      mem_wb_q <= '0;
    end else begin
      pc_q     <= br_taken ? ex_mem_q.target : pc4_f;
      if_id_q  <= br_taken ? '0 : if_id_d;
      id_ex_q  <= br_taken ? '0 : id_ex_d;
      ex_mem_q <= br_taken ? '0 : ex_mem_d;
      mem_wb_q <= mem_wb_d;
    end
  end
endmodule

// File: rtl/core_pipe5_chk.sv
`timescale 1ns/1ps
module core_pipe5_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] imem_addr_i,
  input logic        dmem_we_i,
  input logic        taken_i,
  input logic [4:0]  rs_addr_i,
  input logic [31:0] rs_data_i
);
  logic past_valid;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_valid |-> (!dmem_we_i && imem_addr_i == 32'd0)); // R1

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid && !$past(taken_i)) |-> (imem_addr_i == $past(imem_addr_i) + 32'd4)); // R2

  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_i[1:0] == 2'b00); // R2

  AST_FLUSH_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_i |=> (!dmem_we_i && !taken_i)); // R7

  AST_ZERO_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_addr_i == 5'd0) |-> (rs_data_i == 32'd0)); // R8
endmodule

bind core_pipe5 core_pipe5_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_addr_i (imem_addr_o),
  .dmem_we_i   (dmem_we_o),
  .taken_i     (br_taken),
  .rs_addr_i   (rs_addr),
  .rs_data_i   (rs_data)
);

// File: tb/core_pipe5_bench.sv
`timescale 1ns/1ps
module core_pipe5_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  always #2.5 clk_i = ~clk_i;

  core_pipe5 u_core_pipe5 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_rdata_i(dmem_rdata)
  );

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk_i) if (rst_ni && dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    int          cyc;
    string       req;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0, pos = 0;
  bit done = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic put(input logic [31:0] w); imem[pos] = w; pos++; endtask
  task automatic expect_st(input logic [31:0] a, d, input int c, input string req);
    exp_t e;
    e.addr = a; e.data = d; e.cyc = c; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && dmem_we) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected store addr", dmem_addr, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(dmem_addr == e.addr, e.req, "store addr", dmem_addr, e.addr);
        chk(dmem_wdata == e.data, e.req, "store data", dmem_wdata, e.data);
        chk(cyc == e.cyc, e.req, "store cycle", 32'(cyc), 32'(e.cyc));
      end
    end
  end

  task automatic begin_prog();
    rst_ni = 1'b0;
    q.delete();
    pos = 0;
    for (int i = 0; i < 256; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
  endtask

  task automatic go();
    @(negedge clk_i);
    @(negedge clk_i);
    chk(imem_addr == 32'h0, "R1", "fetch addr in reset", imem_addr, 32'h0);
    chk(dmem_we == 1'b0, "R1", "write enable in reset", 32'(dmem_we), 32'h0);
    #1 rst_ni = 1'b1;
  endtask

  task automatic finish_prog(input int upto);
    while (cyc < upto) @(negedge clk_i);
    chk(q.size() == 0, "R10", "pending stores", 32'(q.size()), 32'h0);
  endtask

  initial begin
    // Program A: arithmetic, zero-extension, r0, two-nop bypass, back-to-back stores
    begin_prog();
    put(enc_i(6'h0D, 0, 1, 16'h0005));
    put(enc_i(6'h0D, 0, 2, 16'h8003));          // R4 zero-extend
    put(0); put(0);
    put(enc_r(1, 2, 3, 6'h20));                 // R9 exactly two nops
    put(enc_r(1, 2, 4, 6'h22));
    put(enc_i(6'h0D, 0, 0, 16'h1234));          // R8 write to r0
    put(0); put(0);
    put(enc_i(6'h2B, 0, 3, 16'h0000));
    put(enc_i(6'h2B, 0, 4, 16'h0004));
    put(enc_i(6'h2B, 0, 0, 16'h0008));
    put(enc_i(6'h2B, 0, 2, 16'h000C));
    expect_st(32'h0, 32'h0000_8008, 12, "R3");
    expect_st(32'h4, 32'hFFFF_8002, 13, "R3");
    expect_st(32'h8, 32'h0000_0000, 14, "R8");
    expect_st(32'hC, 32'h0000_8003, 15, "R6");  // R10 consecutive cycles
    go();
    repeat (8) begin
      @(negedge clk_i);
      chk(imem_addr == 32'(cyc * 4), "R2", "sequential fetch", imem_addr, 32'(cyc * 4));
    end
    finish_prog(24);

    // Program B: load with negative displacement, loaded value reused
    begin_prog();
    dmem[10] = 32'hCAFE_0001;
    put(enc_i(6'h0D, 0, 5, 16'd48));
    put(0); put(0);
    put(enc_i(6'h23, 5, 6, 16'hFFF8));          // R5 addr 40
    put(0); put(0);
    put(enc_i(6'h2B, 0, 6, 16'd16));
    put(enc_r(6, 5, 7, 6'h20));
    put(0); put(0);
    put(enc_i(6'h2B, 0, 7, 16'd20));
    expect_st(32'd16, 32'hCAFE_0001, 9, "R5");
    expect_st(32'd20, 32'hCAFE_0031, 13, "R9");
    go();
    finish_prog(24);

    // Program C: untaken then taken branch with stores and a write in the shadow
    begin_prog();
    put(enc_i(6'h0D, 0, 1, 16'd7));
    put(enc_i(6'h0D, 0, 2, 16'd7));
    put(enc_i(6'h0D, 0, 3, 16'd9));
    put(0); put(0);
    put(enc_i(6'h04, 1, 3, 16'd14));            // not taken
    put(enc_i(6'h2B, 0, 1, 16'h0020));
    put(enc_i(6'h04, 1, 2, 16'd6));             // taken -> slot 14
    put(enc_i(6'h2B, 0, 3, 16'h0040));          // flushed
    put(enc_i(6'h0D, 0, 1, 16'h0055));          // flushed
    put(enc_i(6'h2B, 0, 3, 16'h0044));          // flushed
    put(enc_i(6'h2B, 0, 3, 16'h0048));          // skipped
    put(enc_i(6'h2B, 0, 3, 16'h004C));          // skipped
    put(enc_i(6'h2B, 0, 3, 16'h0050));          // skipped
    put(enc_i(6'h2B, 0, 2, 16'h0028));
    put(enc_i(6'h2B, 0, 1, 16'h002C));
    expect_st(32'h20, 32'd7, 9, "R7");
    expect_st(32'h28, 32'd7, 14, "R7");
    expect_st(32'h2C, 32'd7, 15, "R7");
    go();
    while (cyc < 11) @(negedge clk_i);
    chk(imem_addr == 32'd56, "R7", "branch target fetch", imem_addr, 32'd56);
    finish_prog(30);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule